// File: doc/BRIEF.md
# Video Bridge Configuration Register File

This block is the configuration and status register slave of a serial-video to flat-panel bridge. A host reaches it through a simple synchronous port: a write strobe with address and data, and a read strobe whose data comes back on the next clock. The space has 8-bit addresses and 8-bit data. It holds nine fixed identification bytes, a write-only soft reset command, the clock generator controls, the lane and output format settings, the video timing bytes and an error interrupt group. Each address has its own read and write permission. Reads of an address with no read permission return zero, and writes to an address with no write permission change nothing.

The clock generator fields and the active-area sizes are decoded into their own output ports, so the datapath needs no byte decode. A lock indication from the clock generator is visible as a read-only bit. Error pulses from the datapath set sticky status bits. The host clears them by writing ones. An interrupt output is raised when an enabled status bit is set and the global interrupt enable is on. Writing the soft reset command runs a two-state sequencer, which issues a one-cycle reset pulse to the datapath.

Top module: `vbridge_regfile`

## Requirements
- R1: After reset, every stored register reads 0x00 and `rdata`, `irq`, `dp_rst` and all decoded fields are 0.
- R2: `rdata` takes the value of the addressed register on the clock edge where `rd_en` is sampled high, and it holds that value while `rd_en` is low.
- R3: Addresses 0x00 to 0x08 return byte i of parameter `ID_BYTES` (bits 8i+7..8i) and ignore writes.
- R4: Address 0x09 is write-only and reads 0x00. Writing it with bit 0 set drives `dp_rst` high for exactly one cycle, in the cycle after the write edge.
- R5: Addresses 0x0A, 0x0B, 0x0D, 0x10-0x12, 0x18-0x1B, 0x20, 0x21, 0x24, 0x25, 0x28, 0x29, 0x2C, 0x2D, 0x30, 0x31, 0x34, 0x36, 0x38, 0x3A and 0x3C store the written byte and read it back. The exception is bit 7 of 0x0A, which always reads the `pll_locked` input.
- R6: `clk_range` = 0x0A[3:1], `clk_src` = 0x0A[0], `clk_div` = 0x0B[7:3], `ref_mul` = 0x0B[1:0], `pll_en` = 0x0D[0], `h_active` = {0x21,0x20} and `v_active` = {0x25,0x24}. Each follows a write on the next cycle.
- R7: Any other address (for example 0x0C or 0xE2) reads 0x00, and writes to it alter no register.
- R8: Each pulse on `err_evt` sets the status bit in the same position at 0xE5, whatever the enables are, and the bit stays set. The bit positions are: 7 sync, 6 checksum, 5 uncorrectable ECC, 4 correctable ECC, 3 low-level protocol, 2 start-of-transmission, 0 clock-generator unlock. Bit 1 is unused and reads 0.
- R9: Writing 0xE5 clears each status bit written as 1 and leaves the others unchanged.
- R10: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: 0xE0 bit 0 is the global enable, and its bits 7:1 read 0. 0xE1 holds per-source enables in the status positions, and its bit 1 reads 0. `irq` = 0xE0[0] AND OR(status AND enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| err_evt | input | 8 | Error event pulses, status bit positions |
| pll_locked | input | 1 | Clock generator lock indication |
| irq | output | 1 | Interrupt request |
| dp_rst | output | 1 | One-cycle datapath reset pulse |
| pll_en | output | 1 | Clock generator enable |
| clk_range | output | 3 | Output clock range code |
| clk_src | output | 1 | Clock source select |
| clk_div | output | 5 | Clock divider |
| ref_mul | output | 2 | Reference multiplier |
| h_active | output | 16 | Active pixels per line |
| v_active | output | 16 | Active lines per frame |

## Verification
Read data is due one edge after the read strobe is sampled. Decoded fields, status bits and `irq` are due one edge after the write or event that changes them. `dp_rst` is high for the single cycle after the edge that takes the soft reset write. The bench drives every stimulus on a falling edge and then samples the result at the following falling edge. That is exactly one rising edge later, so each register stage is counted once. The pulse is checked on that falling edge and checked again one cycle later to confirm it is low.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NUM_ID = 9;
    localparam int NSLOT  = 25;
    localparam int SLOT_W = $clog2(NSLOT);

    localparam logic [ADDR_W-1:0] A_SRST  = 8'h09;
    localparam logic [ADDR_W-1:0] A_GIE   = 8'hE0;
    localparam logic [ADDR_W-1:0] A_IEN   = 8'hE1;
    localparam logic [ADDR_W-1:0] A_ISTAT = 8'hE5;
    localparam logic [DATA_W-1:0] ERR_MASK = 8'hFD;

    // plain stored registers; slot order fixes the decoded-field indices below
    localparam logic [ADDR_W-1:0] SLOT_ADDR [NSLOT] = '{
        8'h0A, 8'h0B, 8'h0D, 8'h10, 8'h11, 8'h12, 8'h18, 8'h19, 8'h1A, 8'h1B,
        8'h20, 8'h21, 8'h24, 8'h25, 8'h28, 8'h29, 8'h2C, 8'h2D, 8'h30, 8'h31,
        8'h34, 8'h36, 8'h38, 8'h3A, 8'h3C};
    localparam int S_CLKCTL = 0;
    localparam int S_DIV    = 1;
    localparam int S_PLLEN  = 2;
    localparam int S_HACT_L = 10;
    localparam int S_HACT_H = 11;
    localparam int S_VACT_L = 12;
    localparam int S_VACT_H = 13;

    typedef enum logic [0:0] {SR_IDLE, SR_PULSE} srst_state_t;

    function automatic logic slot_hit(input logic [ADDR_W-1:0] a);
        logic h;
        h = 1'b0;
        for (int i = 0; i < NSLOT; i++) if (SLOT_ADDR[i] == a) h = 1'b1;
        return h;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_idx(input logic [ADDR_W-1:0] a);
        logic [SLOT_W-1:0] s;
        s = '0;
        for (int i = 0; i < NSLOT; i++) if (SLOT_ADDR[i] == a) s = SLOT_W'(i);
        return s;
    endfunction

    function automatic logic readable(input logic [ADDR_W-1:0] a);
        return (a < ADDR_W'(NUM_ID)) || slot_hit(a) ||
               (a == A_GIE) || (a == A_IEN) || (a == A_ISTAT);
    endfunction
endpackage

// File: rtl/vbr_addr_decode.sv
module vbr_addr_decode
    import vbr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              is_id,
    output logic              is_slot,
    output logic [SLOT_W-1:0] slot,
    output logic              is_srst,
    output logic              is_gie,
    output logic              is_ien,
    output logic              is_stat
);
    always_comb begin
        is_id   = addr < ADDR_W'(NUM_ID);
        is_slot = slot_hit(addr);
        slot    = slot_idx(addr);
        is_srst = addr == A_SRST;
        is_gie  = addr == A_GIE;
        is_ien  = addr == A_IEN;
        is_stat = addr == A_ISTAT;
    end
endmodule

// File: rtl/vbr_cfg_store.sv
module vbr_cfg_store
    import vbr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [SLOT_W-1:0]             slot,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NSLOT-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // bit 7 of the clock control byte is the live lock flag, not stored
        localparam logic [DATA_W-1:0] KEEP = (g == S_CLKCTL) ? 8'h7F : 8'hFF;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q[g] <= '0;
            else if (wr && slot == SLOT_W'(g)) q[g] <= wdata & KEEP;
        end
    end
endmodule

// File: rtl/vbr_irq_block.sv
module vbr_irq_block
    import vbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_gie,
    input  logic              wr_ien,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] err_evt,
    output logic              gie,
    output logic [DATA_W-1:0] ien,
    output logic [DATA_W-1:0] stat,
    output logic              irq
);
    logic [DATA_W-1:0] clr;
    assign clr = wr_stat ? (wdata & ERR_MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie  <= 1'b0;
            ien  <= '0;
            stat <= '0;
        end else begin
            if (wr_gie) gie <= wdata[0];
            if (wr_ien) ien <= wdata & ERR_MASK;
            // event set is applied after the clear, so it wins a collision
            stat <= (stat & ~clr) | (err_evt & ERR_MASK);
        end
    end

    assign irq = gie && |(stat & ien);
endmodule

// File: rtl/vbr_srst_fsm.sv
module vbr_srst_fsm
    import vbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);
    srst_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SR_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SR_IDLE:  if (req) nxt = SR_PULSE;
            SR_PULSE: nxt = SR_IDLE;
        endcase
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state)
            SR_IDLE:  pulse = 1'b0;
            SR_PULSE: pulse = 1'b1;
        endcase
    end
endmodule

// File: rtl/vbridge_regfile.sv
module vbridge_regfile
    import vbr_pkg::*;
#(
    parameter logic [NUM_ID*DATA_W-1:0] ID_BYTES = 72'h5A3C960FE17B22C418
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] err_evt,
    input  logic              pll_locked,
    output logic              irq,
    output logic              dp_rst,
    output logic              pll_en,
    output logic [2:0]        clk_range,
    output logic              clk_src,
    output logic [4:0]        clk_div,
    output logic [1:0]        ref_mul,
    output logic [15:0]       h_active,
    output logic [15:0]       v_active
);
    logic                         is_id, is_slot, is_srst, is_gie, is_ien, is_stat;
    logic [SLOT_W-1:0]            slot;
    logic [NSLOT-1:0][DATA_W-1:0] cfg;
    logic                         irq_gie;
    logic [DATA_W-1:0]            irq_ien, irq_stat, rd_mux;

    vbr_addr_decode u_dec (
        .addr(addr), .is_id(is_id), .is_slot(is_slot), .slot(slot),
        .is_srst(is_srst), .is_gie(is_gie), .is_ien(is_ien), .is_stat(is_stat)
    );

    vbr_cfg_store u_store (
        .clk(clk), .rst_n(rst_n), .wr(wr_en && is_slot),
        .slot(slot), .wdata(wdata), .q(cfg)
    );

    vbr_irq_block u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_gie(wr_en && is_gie), .wr_ien(wr_en && is_ien), .wr_stat(wr_en && is_stat),
        .wdata(wdata), .err_evt(err_evt),
        .gie(irq_gie), .ien(irq_ien), .stat(irq_stat), .irq(irq)
    );

    vbr_srst_fsm u_srst (
        .clk(clk), .rst_n(rst_n), .req(wr_en && is_srst && wdata[0]), .pulse(dp_rst)
    );

    always_comb begin
        rd_mux = '0;
        if (is_id)
            rd_mux = ID_BYTES[int'(addr)*DATA_W +: DATA_W];
        else if (is_slot)
            rd_mux = cfg[slot] | ((slot == SLOT_W'(S_CLKCTL)) ? {pll_locked, 7'b0} : 8'h00);
        else if (is_gie)
            rd_mux = {7'b0, irq_gie};
        else if (is_ien)
            rd_mux = irq_ien;
        else if (is_stat)
            rd_mux = irq_stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign clk_range = cfg[S_CLKCTL][3:1];
    assign clk_src   = cfg[S_CLKCTL][0];
    assign clk_div   = cfg[S_DIV][7:3];
    assign ref_mul   = cfg[S_DIV][1:0];
    assign pll_en    = cfg[S_PLLEN][0];
    assign h_active  = {cfg[S_HACT_H], cfg[S_HACT_L]};
    assign v_active  = {cfg[S_VACT_H], cfg[S_VACT_L]};
endmodule

// File: rtl/vbridge_regfile_chk.sv
module vbridge_regfile_chk
    import vbr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] err_evt,
    input logic              pll_locked,
    input logic              irq,
    input logic              dp_rst,
    input logic [DATA_W-1:0] status
);
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |=> !dp_rst);

    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |-> $past(wr_en && addr == A_SRST && wdata[0]));

    a_r5_lock_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h0A) |=> rdata[7] == $past(pll_locked));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !readable(addr)) |=> rdata == 8'h00);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_evt & ERR_MASK)) |=>
            ((status & $past(err_evt & ERR_MASK)) == $past(err_evt & ERR_MASK)));

    a_r11_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h00) |-> !irq);
endmodule

bind vbridge_regfile vbridge_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err_evt(err_evt), .pll_locked(pll_locked),
    .irq(irq), .dp_rst(dp_rst), .status(irq_stat)
);

// File: tb/tb_vbridge_regfile.sv
module tb_vbridge_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pll_locked = 1'b0;
    logic [7:0]  addr = '0, wdata = '0, err_evt = '0;
    logic [7:0]  rdata;
    logic        irq, dp_rst, pll_en, clk_src;
    logic [2:0]  clk_range;
    logic [4:0]  clk_div;
    logic [1:0]  ref_mul;
    logic [15:0] h_active, v_active;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    vbridge_regfile dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err_evt(err_evt), .pll_locked(pll_locked),
        .irq(irq), .dp_rst(dp_rst), .pll_en(pll_en), .clk_range(clk_range),
        .clk_src(clk_src), .clk_div(clk_div), .ref_mul(ref_mul),
        .h_active(h_active), .v_active(v_active)
    );

    typedef struct packed {
        logic       rd;
        logic [7:0] a;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 8'h18, 4'd3},  // R3 id byte 0
        '{1'b0, 8'h03, 8'hFF, 4'd3},  // R3 write to id is ignored
        '{1'b1, 8'h03, 8'h7B, 4'd3},
        '{1'b1, 8'h08, 8'h5A, 4'd3},
        '{1'b0, 8'h0B, 8'hA5, 4'd5},  // R5 stored bytes
        '{1'b1, 8'h0B, 8'hA5, 4'd5},
        '{1'b0, 8'h10, 8'h3C, 4'd5},
        '{1'b1, 8'h10, 8'h3C, 4'd5},
        '{1'b0, 8'h3C, 8'h81, 4'd5},
        '{1'b1, 8'h3C, 8'h81, 4'd5},
        '{1'b0, 8'h20, 8'h80, 4'd5},
        '{1'b0, 8'h21, 8'h07, 4'd5},
        '{1'b1, 8'h21, 8'h07, 4'd5},
        '{1'b0, 8'h0C, 8'h55, 4'd7},  // R7 hole in the map
        '{1'b1, 8'h0C, 8'h00, 4'd7},
        '{1'b1, 8'h0B, 8'hA5, 4'd7},
        '{1'b0, 8'hE2, 8'h11, 4'd7},
        '{1'b1, 8'hE2, 8'h00, 4'd7},
        '{1'b0, 8'h0A, 8'hFF, 4'd5},  // R5 lock bit follows input (low)
        '{1'b1, 8'h0A, 8'h7F, 4'd5},
        '{1'b0, 8'hE1, 8'hFF, 4'd11}, // R11 enable masks
        '{1'b1, 8'hE1, 8'hFD, 4'd11},
        '{1'b0, 8'hE0, 8'hFF, 4'd11},
        '{1'b1, 8'hE0, 8'h01, 4'd11},
        '{1'b1, 8'h09, 8'h00, 4'd4},  // R4 write-only reads zero
        '{1'b1, 8'h0D, 8'h00, 4'd1}   // R1 reset value
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic evt(input logic [7:0] e);
        @(negedge clk); err_evt = e;
        @(negedge clk); err_evt = '0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", 16'(rdata), 16'h0);
        chk("R1 irq/dp_rst/pll_en", {13'b0, irq, dp_rst, pll_en}, 16'h0);
        chk("R1 clk_div", 16'(clk_div), 16'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].a, v);
                chk($sformatf("R%0d table[%0d] addr %h", VEC[i].req, i, VEC[i].a), 16'(v), 16'(VEC[i].d));
            end else begin
                wr(VEC[i].a, VEC[i].d);
            end
        end

        // R6 decoded fields
        chk("R6 clk_div", 16'(clk_div), 16'h14);
        chk("R6 ref_mul", 16'(ref_mul), 16'h1);
        chk("R6 clk_range", 16'(clk_range), 16'h7);
        chk("R6 clk_src", 16'(clk_src), 16'h1);
        chk("R6 h_active", h_active, 16'h0780);
        chk("R6 v_active", v_active, 16'h0000);
        wr(8'h0D, 8'h01);
        chk("R6 pll_en", 16'(pll_en), 16'h1);

        // R5 lock bit high, then R2 hold
        pll_locked = 1'b1;
        rd(8'h0A, v);
        chk("R5 lock bit", 16'(v), 16'h00FF);
        @(negedge clk); addr = 8'h00;
        @(negedge clk);
        chk("R2 hold without strobe", 16'(rdata), 16'h00FF);

        // R4 soft reset pulse
        chk("R4 idle", 16'(dp_rst), 16'h0);
        wr(8'h09, 8'h01);
        chk("R4 pulse high", 16'(dp_rst), 16'h1);
        @(negedge clk);
        chk("R4 pulse one cycle", 16'(dp_rst), 16'h0);

        // R8 sticky status independent of enables
        wr(8'hE0, 8'h00);
        wr(8'hE1, 8'h00);
        evt(8'h84);
        chk("R8 no irq when disabled", 16'(irq), 16'h0);
        rd(8'hE5, v);
        chk("R8 status", 16'(v), 16'h0084);
        evt(8'h02);
        rd(8'hE5, v);
        chk("R8 unused bit 1", 16'(v), 16'h0084);

        // R11 interrupt gating
        wr(8'hE1, 8'h04);
        chk("R11 global off", 16'(irq), 16'h0);
        wr(8'hE0, 8'h01);
        chk("R11 irq on", 16'(irq), 16'h1);

        // R9 write-one-to-clear
        wr(8'hE5, 8'h04);
        chk("R9 irq cleared", 16'(irq), 16'h0);
        rd(8'hE5, v);
        chk("R9 other bit kept", 16'(v), 16'h0080);

        // R10 set wins over clear
        @(negedge clk); wr_en = 1'b1; addr = 8'hE5; wdata = 8'h81; err_evt = 8'h01;
        @(negedge clk); wr_en = 1'b0; err_evt = 8'h00;
        rd(8'hE5, v);
        chk("R10 collision", 16'(v), 16'h0001);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule